// File: doc/BRIEF.md
# Capture/Compare Timer Channel with Handshake-Cleared Status Flags

This block is a single timer channel built around a free-running up-counter that advances once per clock. Beside the counter sit two general registers, A and B. Each one works either as an input-capture register or as an output-compare register. In capture mode, a rising edge on the register's capture input stores the counter value. In compare mode, the register raises an event whenever the counter equals its contents.

Three events are latched in a status register:
- counter wrap-around,
- the register A event,
- the register B event.

Each latched flag drives an interrupt request through its own enable bit.

Software reaches the counter, both general registers, a control register and the status register over a simple single-cycle register bus. Reads are combinational from the address. A flag can be cleared only by a two-step handshake. Software first reads the status register and sees the flag as 1, which arms that flag. Software then writes 0 to the flag's bit.

Top module: `capCmpTimer`

## Requirements
- R1: While reset is held, the counter, both general registers, the control register and all three flags read as 0, and all interrupt requests are 0.
- R2: The status register (address 4) holds the register A flag at bit 0, the register B flag at bit 1 and the overflow flag at bit 2. All higher bits read as 0, and writes to them have no effect.
- R3: The overflow flag sets on the clock edge at which the counter steps from all ones to 0. The counter steps on every clock that carries no bus write to the counter.
- R4: In compare mode, a register's flag sets on the clock edge that ends a cycle in which the counter equals that register. In this mode the capture input is ignored and the register keeps its value.
- R5: In capture mode, the capture input passes through a two-flop synchronizer. A rising edge on it loads the register, and the flag sets on the third clock edge after the input rises. The value loaded is the counter value two edges after the one that first samples the input high. In this mode, counter equality does not set the flag.
- R6: Writing 0 to a flag bit clears the flag only if a status read has returned that flag as 1 since the last clear. Writing 1 to a flag bit has no effect and keeps the armed state.
- R7: A write of 0 to a flag that has not been armed by a read leaves it set. A clearing write consumes the arming, so a later write of 0 with no new read leaves a newly set flag at 1.
- R8: When a set condition and a valid clearing write hit the same flag on the same edge, the flag stays 1.
- R9: Each interrupt request (irqA, irqB, irqOvf) equals its flag ANDed with its enable bit in the control register.
- R10: The bus map is as follows.
  - Address 0 is the counter, 1 is register A, 2 is register B and 3 is the control register.
  - In the control register, bit 0 selects capture mode for A (1 = capture) and bit 1 does the same for B. Bits 4, 5 and 6 are the interrupt enables for A, B and overflow.
  - A counter write takes priority over the increment, and the counter resumes counting from the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | ADDR_W | Register select for reads and writes |
| busRd | input | 1 | Read strobe; a read of the status address arms flags reading 1 |
| busWr | input | 1 | Write strobe |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Combinational read data for busAddr |
| capInA | input | 1 | Asynchronous capture input for register A |
| capInB | input | 1 | Asynchronous capture input for register B |
| irqA | output | 1 | Register A interrupt request |
| irqB | output | 1 | Register B interrupt request |
| irqOvf | output | 1 | Counter overflow interrupt request |

## Verification
The properties assume one bus operation per cycle. In particular, they assume a status read and a status write never share a cycle, since a flag's clearing is judged only against that cycle's write. The bench keeps to this rule because every access goes through a read task or a write task, and each task occupies its own cycle.

The capture inputs are driven on falling clock edges and held high for several cycles. A rising edge therefore always reaches the synchronizer once, and no pulse is shorter than a clock period.

The bench sweeps compare values and capture start values across the 16-bit wrap boundary. It also places the clearing write on exactly the edge of a compare match, by counting cycles from a counter write.

// File: rtl/capCmpTimer_pkg.sv
package capCmpTimer_pkg;
  // bus address map
  localparam int ADDR_CNT  = 0;
  localparam int ADDR_GRA  = 1;
  localparam int ADDR_GRB  = 2;
  localparam int ADDR_CTL  = 3;
  localparam int ADDR_STAT = 4;

  // status bit positions
  localparam int FLG_A   = 0;
  localparam int FLG_B   = 1;
  localparam int FLG_OVF = 2;
  localparam int NUM_FLG = 3;

  // decoded bus strobes from control to datapath
  typedef struct packed {
    logic wrCnt;
    logic wrGrA;
    logic wrGrB;
    logic wrCtl;
    logic wrStat;
    logic rdStat;
  } busStrobe_t;

  // events raised by the datapath
  typedef struct packed {
    logic ovf;
    logic hitB;
    logic hitA;
  } tmrEvent_t;
endpackage

// File: rtl/capCmpTimerSync.sv
module capCmpTimerSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[STAGES-1:0], din};
  end

  // rising edge seen at the output of the last synchronizing stage
  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/capCmpTimerDp.sv
module capCmpTimerDp
  import capCmpTimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  busStrobe_t        st,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        capIn,
  input  logic [NUM_FLG-1:0] flags,
  output logic [CNT_W-1:0]  rdata,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  grA,
  output logic [CNT_W-1:0]  grB,
  output logic [1:0]        capMode,
  output logic [NUM_FLG-1:0] irqEn,
  output tmrEvent_t         ev
);
  localparam int NUM_GR = 2;

  logic [CNT_W-1:0] gr [NUM_GR];
  logic [NUM_GR-1:0] capRise;
  logic [NUM_GR-1:0] hit;
  logic [NUM_GR-1:0] grWr;
  logic [CNT_W-1:0] ctlView;

  assign grWr = {st.wrGrB, st.wrGrA};

  // free-running counter, bus write has priority
  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (st.wrCnt) cnt <= wdata;
    else               cnt <= cnt + 1'b1;
  end

  assign ev.ovf = ~st.wrCnt & (cnt == {CNT_W{1'b1}});

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      capMode <= '0;
      irqEn   <= '0;
    end else if (st.wrCtl) begin
      capMode <= wdata[1:0];
      irqEn   <= wdata[6:4];
    end
  end

  // general registers, one instance of logic per register
  for (genvar ch = 0; ch < NUM_GR; ch++) begin : g_gr
    capCmpTimerSync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (capIn[ch]),
      .rise(capRise[ch])
    );

    always_ff @(posedge clk) begin
      if (rst)                           gr[ch] <= '0;
      else if (capMode[ch] && capRise[ch]) gr[ch] <= cnt;
      else if (grWr[ch])                 gr[ch] <= wdata;
    end

    assign hit[ch] = capMode[ch] ? capRise[ch] : (cnt == gr[ch]);
  end

  assign ev.hitA = hit[0];
  assign ev.hitB = hit[1];
  assign grA = gr[0];
  assign grB = gr[1];

  always_comb begin
    ctlView = '0;
    ctlView[1:0] = capMode;
    ctlView[6:4] = irqEn;
  end

  always_comb begin
    case (addr)
      ADDR_W'(ADDR_CNT):  rdata = cnt;
      ADDR_W'(ADDR_GRA):  rdata = gr[0];
      ADDR_W'(ADDR_GRB):  rdata = gr[1];
      ADDR_W'(ADDR_CTL):  rdata = ctlView;
      ADDR_W'(ADDR_STAT): rdata = CNT_W'(flags);
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/capCmpTimerCtl.sv
module capCmpTimerCtl
  import capCmpTimer_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rd,
  input  logic               wr,
  input  logic [NUM_FLG-1:0] wdataLo,
  input  tmrEvent_t          ev,
  input  logic [NUM_FLG-1:0] irqEn,
  output busStrobe_t         st,
  output logic [NUM_FLG-1:0] flags,
  output logic [NUM_FLG-1:0] irq
);
  logic [NUM_FLG-1:0] armed;
  logic [NUM_FLG-1:0] setVec;
  logic [NUM_FLG-1:0] clrVec;
  logic [NUM_FLG-1:0] armVec;

  // bus decode
  always_comb begin
    st.wrCnt  = wr && (addr == ADDR_W'(ADDR_CNT));
    st.wrGrA  = wr && (addr == ADDR_W'(ADDR_GRA));
    st.wrGrB  = wr && (addr == ADDR_W'(ADDR_GRB));
    st.wrCtl  = wr && (addr == ADDR_W'(ADDR_CTL));
    st.wrStat = wr && (addr == ADDR_W'(ADDR_STAT));
    st.rdStat = rd && (addr == ADDR_W'(ADDR_STAT));
  end

  assign setVec = {ev.ovf, ev.hitB, ev.hitA};
  assign armVec = {NUM_FLG{st.rdStat}} & flags;
  assign clrVec = {NUM_FLG{st.wrStat}} & ~wdataLo & armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      armed <= '0;
    end else begin
      // a set on the same edge as a clear wins
      flags <= setVec | (flags & ~clrVec);
      armed <= (armed & ~clrVec) | armVec;
    end
  end

  assign irq = flags & irqEn;
endmodule

// File: rtl/capCmpTimer.sv
module capCmpTimer
  import capCmpTimer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  input  logic              capInA,
  input  logic              capInB,
  output logic              irqA,
  output logic              irqB,
  output logic              irqOvf
);
  busStrobe_t          st;
  tmrEvent_t           ev;
  logic [NUM_FLG-1:0]  flags;
  logic [NUM_FLG-1:0]  irqEn;
  logic [NUM_FLG-1:0]  irq;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    grA;
  logic [CNT_W-1:0]    grB;
  logic [1:0]          capMode;

  capCmpTimerDp #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .st     (st),
    .wdata  (busWdata),
    .addr   (busAddr),
    .capIn  ({capInB, capInA}),
    .flags  (flags),
    .rdata  (busRdata),
    .cnt    (cnt),
    .grA    (grA),
    .grB    (grB),
    .capMode(capMode),
    .irqEn  (irqEn),
    .ev     (ev)
  );

  capCmpTimerCtl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk    (clk),
    .rst    (rst),
    .addr   (busAddr),
    .rd     (busRd),
    .wr     (busWr),
    .wdataLo(busWdata[NUM_FLG-1:0]),
    .ev     (ev),
    .irqEn  (irqEn),
    .st     (st),
    .flags  (flags),
    .irq    (irq)
  );

  assign irqA   = irq[FLG_A];
  assign irqB   = irq[FLG_B];
  assign irqOvf = irq[FLG_OVF];
endmodule

// File: rtl/capCmpTimerChk.sv
module capCmpTimerChk
  import capCmpTimer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [CNT_W-1:0]  busWdata,
  input logic [CNT_W-1:0]  busRdata,
  input logic [2:0]        flags,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  grA,
  input logic [CNT_W-1:0]  grB,
  input logic [1:0]        capMode
);
  logic statWr;
  logic cntWr;
  assign statWr = busWr && (busAddr == ADDR_W'(ADDR_STAT));
  assign cntWr  = busWr && (busAddr == ADDR_W'(ADDR_CNT));

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (busRd && busAddr == ADDR_W'(ADDR_STAT)) |-> (busRdata[CNT_W-1:3] == '0));

  p_ovf_set_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == {CNT_W{1'b1}} && !cntWr) |=> flags[FLG_OVF]);

  p_cmp_set_a_r4: assert property (@(posedge clk) disable iff (rst)
    (!capMode[0] && cnt == grA) |=> flags[FLG_A]);

  p_cmp_set_b_r4: assert property (@(posedge clk) disable iff (rst)
    (!capMode[1] && cnt == grB) |=> flags[FLG_B]);

  p_fall_a_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[FLG_A]) |-> $past(statWr && !busWdata[FLG_A]));

  p_fall_b_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[FLG_B]) |-> $past(statWr && !busWdata[FLG_B]));

  p_fall_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(flags[FLG_OVF]) |-> $past(statWr && !busWdata[FLG_OVF]));

  p_cnt_step_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(cntWr)) |-> (cnt == $past(cnt) + 1'b1));
endmodule

bind capCmpTimer capCmpTimerChk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busAddr (busAddr),
  .busRd   (busRd),
  .busWr   (busWr),
  .busWdata(busWdata),
  .busRdata(busRdata),
  .flags   (flags),
  .cnt     (cnt),
  .grA     (grA),
  .grB     (grB),
  .capMode (capMode)
);

// File: tb/sim_capCmpTimer.sv
`timescale 1ns/1ps
module sim_capCmpTimer;
  localparam int CW = 16;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CNT = 0, A_GRA = 1, A_GRB = 2, A_CTL = 3, A_STAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic busRd = 1'b0;
  logic busWr = 1'b0;
  logic [CW-1:0] busWdata = '0;
  logic [CW-1:0] busRdata;
  logic [1:0] capIn = 2'b00;
  logic irqA, irqB, irqOvf;
  logic [2:0] irqV;
  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  capCmpTimer #(.CNT_W(CW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .capInA(capIn[0]), .capInB(capIn[1]),
    .irqA(irqA), .irqB(irqB), .irqOvf(irqOvf)
  );

  assign irqV = {irqOvf, irqB, irqA};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic clearAll();
    logic [CW-1:0] tmp;
    busRead(A_STAT, tmp);
    busWrite(A_STAT, '0);
  endtask

  task automatic cmpTest(input int ch, input logic [CW-1:0] val);
    logic [AW-1:0] ga;
    ga = (ch == 0) ? A_GRA : A_GRB;
    busWrite(ga, val);
    busWrite(A_CNT, val ^ 16'h8000);
    clearAll();
    busWrite(A_CNT, val - 16'd3);
    chk("R4 compare idle", 32'(irqV[ch]), 0);
    repeat (3) @(negedge clk);
    chk("R4 compare before match edge", 32'(irqV[ch]), 0);
    @(negedge clk);
    chk("R4 compare set on match", 32'(irqV[ch]), 1);
  endtask

  task automatic capTest(input int ch, input logic [CW-1:0] c);
    logic [AW-1:0] ga;
    logic [CW-1:0] d;
    logic [CW-1:0] expV;
    ga = (ch == 0) ? A_GRA : A_GRB;
    expV = c + 16'd2;
    busWrite(A_CTL, 16'h0070 | CW'(1 << ch));
    busWrite(A_CNT, c ^ 16'h8000);
    clearAll();
    busWrite(A_CNT, c);
    capIn[ch] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 capture latency, not yet", 32'(irqV[ch]), 0);
    @(negedge clk);
    chk("R5 capture flag set", 32'(irqV[ch]), 1);
    capIn[ch] = 1'b0;
    busRead(ga, d);
    chk("R5 captured value", 32'(d), 32'(expV));
    clearAll();
    busWrite(A_CNT, expV - 16'd3);
    repeat (6) @(negedge clk);
    chk("R5 equality ignored in capture mode", 32'(irqV[ch]), 0);
    busWrite(A_CTL, 16'h0070);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d;
    logic [CW-1:0] cmpVals [8];
    logic [CW-1:0] capVals [4];
    cmpVals = '{16'h0005, 16'h0000, 16'h0001, 16'h0002, 16'h7FFF, 16'h8000, 16'hFFFE, 16'hFFFF};
    capVals = '{16'h0000, 16'h1234, 16'hFFFD, 16'hFFFE};

    // R1: reset state
    repeat (4) @(negedge clk);
    busAddr = A_STAT; #1 chk("R1 status in reset", 32'(busRdata), 0);
    busAddr = A_CNT;  #1 chk("R1 counter in reset", 32'(busRdata), 0);
    busAddr = A_GRA;  #1 chk("R1 regA in reset", 32'(busRdata), 0);
    busAddr = A_GRB;  #1 chk("R1 regB in reset", 32'(busRdata), 0);
    busAddr = A_CTL;  #1 chk("R1 control in reset", 32'(busRdata), 0);
    chk("R1 irqs in reset", 32'(irqV), 0);
    @(negedge clk);
    rst = 1'b0;

    // R10: bus map and counter write priority
    busWrite(A_CTL, 16'h0073);
    busRead(A_CTL, d);
    chk("R10 control readback", 32'(d), 32'h0073);
    busWrite(A_CTL, 16'h0070);
    busWrite(A_CNT, 16'h1000);
    busRead(A_CNT, d);
    chk("R10 counter resumes from written value", 32'(d), 32'h1001);

    // R4: compare sweep on both registers
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < 8; i++)
        cmpTest(ch, cmpVals[i]);

    // R5: capture sweep on both registers
    for (int ch = 0; ch < 2; ch++)
      for (int i = 0; i < 4; i++)
        capTest(ch, capVals[i]);

    // R4: capture input ignored in compare mode
    busWrite(A_GRA, 16'h4000);
    busWrite(A_CNT, 16'h0100);
    clearAll();
    capIn[0] = 1'b1;
    repeat (4) @(negedge clk);
    capIn[0] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 capture ignored, no flag", 32'(irqA), 0);
    busRead(A_GRA, d);
    chk("R4 capture ignored, value kept", 32'(d), 32'h4000);

    // R3, R6, R7, R2: overflow and clear handshake
    busWrite(A_GRA, 16'h8000);
    busWrite(A_GRB, 16'h8000);
    busWrite(A_CNT, 16'h1000);
    clearAll();
    busRead(A_STAT, d);
    chk("R6 all flags cleared", 32'(d), 0);
    busWrite(A_CNT, 16'hFFFD);
    repeat (2) @(negedge clk);
    chk("R3 no overflow before wrap", 32'(irqOvf), 0);
    @(negedge clk);
    chk("R3 overflow on wrap", 32'(irqOvf), 1);
    busWrite(A_STAT, 16'h0000);
    chk("R7 unarmed write 0 ignored", 32'(irqOvf), 1);
    busRead(A_STAT, d);
    chk("R2 status layout ovf at bit2", 32'(d), 32'h0004);
    busWrite(A_STAT, 16'hFFFF);
    chk("R6 write 1 has no effect", 32'(irqOvf), 1);
    busWrite(A_STAT, 16'h0000);
    chk("R6 armed write 0 clears", 32'(irqOvf), 0);
    busWrite(A_STAT, 16'hFFF8);
    busRead(A_STAT, d);
    chk("R2 upper bits read 0 after write", 32'(d), 0);
    busWrite(A_CNT, 16'hFFFF);
    @(negedge clk);
    chk("R3 overflow again", 32'(irqOvf), 1);
    busWrite(A_STAT, 16'h0000);
    chk("R7 arming consumed by earlier clear", 32'(irqOvf), 1);
    clearAll();
    chk("R6 cleared after new read", 32'(irqOvf), 0);

    // R8: set wins over clear on the same edge
    busWrite(A_GRA, 16'h3000);
    busWrite(A_CNT, 16'h2FFD);
    repeat (5) @(negedge clk);
    busRead(A_STAT, d);
    chk("R2 status layout A at bit0", 32'(d[0]), 1);
    busWrite(A_CNT, 16'h2FFD);
    repeat (2) @(negedge clk);
    busWrite(A_STAT, 16'h0000);
    chk("R8 set wins over clear", 32'(irqA), 1);
    busWrite(A_STAT, 16'h0000);
    chk("R7 no rearm after set-wins", 32'(irqA), 1);

    // R9: interrupt enable gating
    busWrite(A_CTL, 16'h0060);
    chk("R9 irqA masked", 32'(irqA), 0);
    busRead(A_STAT, d);
    chk("R9 flag still held while masked", 32'(d[0]), 1);
    busWrite(A_CTL, 16'h0070);
    chk("R9 irqA unmasked", 32'(irqA), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule